// File: doc/BRIEF.md
# Binary128 to 128-bit integer truncating converter

This unit takes one IEEE 754 binary128 operand and produces a 128-bit two's-complement or unsigned integer. It always rounds toward zero, whatever rounding mode the rest of the machine may be using. A 5-bit sub-operation code selects the integer type. Any code other than the two it accepts is flagged as an illegal operation.

The unit is a single register stage. An operand presented with `in_valid` high at one rising edge gives its result, its invalid-operation flag and its inexact flag at that edge, with `out_valid` high for one cycle. Each operation computes its flags from scratch, so nothing carries over from earlier operations.

NaN inputs and values that cannot be represented give fixed saturated patterns and raise the invalid flag. When a signed conversion is invalid, the low 64 bits of the result are copies of bit 64.

Top module: `qp_trunc_cvt`

## Requirements
- R1: Sub-operation code 5'b00000 selects unsigned conversion and 5'b01000 selects signed conversion. Any other code sets `illegal_op` and gives a zero result with `invalid` and `inexact` both low.
- R2: Outputs are registered only when `in_valid` is high at a rising edge, and `out_valid` is high in the cycle after such an edge. When `in_valid` is low, result and flags keep their values and `out_valid` falls.
- R3: A finite in-range operand converts to its value truncated toward zero. `inexact` is set exactly when nonzero fraction bits are discarded.
- R4: A NaN operand raises `invalid` with `inexact` low. A signed conversion returns high half 0x8000000000000000 and low half zero. An unsigned conversion returns zero.
- R5: A signed conversion of a value of 2^127 or more, including +infinity, returns 0x7FFF...FFFF and raises `invalid`.
- R6: A signed conversion of a value below -2^127, including -infinity, returns 0x8000...0000 and raises `invalid`. The value -2^127 itself converts exactly.
- R7: An unsigned conversion of a negative value whose truncation is nonzero returns zero and raises `invalid`. A value in (-1, 0) returns zero without `invalid`.
- R8: An unsigned conversion of a value of 2^128 or more, including +infinity, returns all ones and raises `invalid`.
- R9: Zeros and subnormals return zero. `inexact` is set only for nonzero subnormals.
- R10: After reset, `out_valid`, the result and all flags are zero. `invalid` and `inexact` are never high together.
- R11: Flags are not sticky: an exact operation that follows an inexact or invalid one reports both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| sub_op | input | 5 | Conversion selector |
| operand | input | 128 | binary128 source value |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 128 | Converted integer |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Discarded-fraction flag |
| illegal_op | output | 1 | Unsupported sub-operation code |

## Verification
Random operands have exponents weighted around the integer range, from just below one up to past 2^128. Their fractions are sometimes cleared in the low bits, so shift positions that drop fraction bits are told apart from exact ones. Directed cases sit on both sides of each saturation edge: -2^127 against slightly below it, 2^127 for signed, and 2^128 for unsigned. Further directed cases cover NaN and both infinities under each signedness, negative fractions under unsigned conversion, zero against subnormal, and unsupported codes. Hold cycles with `in_valid` low and changing inputs show that the outputs are only updated by a strobe.

// File: rtl/qp_trunc_cvt.sv
module qp_trunc_cvt #(
  parameter int W = 128,
  parameter int EW = 15,
  parameter int FW = 112,
  parameter logic [4:0] OP_UNS = 5'b00000,
  parameter logic [4:0] OP_SGN = 5'b01000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [4:0]   sub_op,
  input  logic [W-1:0] operand,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         invalid,
  output logic         inexact,
  output logic         illegal_op
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam int SW   = FW + 1;
  localparam int XW   = 2 * W;
  localparam int SHW  = $clog2(XW);
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] SMAX = ~SMIN;
  localparam logic [W-1:0] UMAX = '1;

  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  assign sgn = operand[W-1];
  assign ex  = operand[W-2:FW];
  assign fr  = operand[FW-1:0];

  logic is_spec, is_nan, is_small, is_big;
  assign is_spec  = &ex;
  assign is_nan   = is_spec && (|fr);
  assign is_small = 32'(ex) < BIAS;
  assign is_big   = 32'(ex) >= BIAS + W;

  logic [31:0]    sh_full;
  logic [SHW-1:0] sh;
  logic [XW-1:0]  wide;
  logic [W-1:0]   mag;
  logic           lost;
  assign sh_full = 32'(ex) - BIAS + (W - FW);
  assign sh      = sh_full[SHW-1:0];
  assign wide    = {{(XW-SW){1'b0}}, 1'b1, fr} << sh;
  assign mag     = wide[XW-1:W];
  assign lost    = |wide[W-1:0];

  logic use_sgn, legal;
  assign use_sgn = sub_op == OP_SGN;
  assign legal   = use_sgn || (sub_op == OP_UNS);

  logic [W-1:0] n_res;
  logic         n_inv, n_inx;

  always_comb begin
    n_res = '0;
    n_inv = 1'b0;
    n_inx = 1'b0;
    if (!legal) begin
      n_res = '0;
    end else if (is_nan) begin
      n_inv = 1'b1;
      n_res = use_sgn ? SMIN : '0;
    end else if (is_spec || is_big) begin
      n_inv = 1'b1;
      if (sgn) n_res = use_sgn ? SMIN : '0;
      else     n_res = use_sgn ? SMAX : UMAX;
    end else if (is_small) begin
      n_inx = (|ex) || (|fr);
    end else if (use_sgn) begin
      if (sgn) begin
        if (mag > SMIN) begin
          n_inv = 1'b1;
          n_res = SMIN;
        end else begin
          n_res = -mag;
          n_inx = lost;
        end
      end else if (mag[W-1]) begin
        n_inv = 1'b1;
        n_res = SMAX;
      end else begin
        n_res = mag;
        n_inx = lost;
      end
    end else if (sgn) begin
      n_inv = 1'b1;
    end else begin
      n_res = mag;
      n_inx = lost;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      result     <= '0;
      invalid    <= 1'b0;
      inexact    <= 1'b0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result     <= n_res;
        invalid    <= n_inv;
        inexact    <= n_inx;
        illegal_op <= !legal;
      end
    end
  end
endmodule

// File: rtl/qp_trunc_cvt_chk.sv
module qp_trunc_cvt_chk #(
  parameter int W = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [4:0]   sub_op,
  input logic [W-1:0] operand,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         invalid,
  input logic         inexact,
  input logic         illegal_op
);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(invalid && inexact));

  assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(invalid) && $stable(inexact)));

  assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (result == '0 && !invalid && !inexact));

  assert_nan_signed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op == 5'b01000 && (&operand[W-2:W-16]) && (|operand[W-17:0]))
    |=> (invalid && result == {1'b1, {(W-1){1'b0}}}));

  assert_uns_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_op == 5'b00000 && operand[W-1]) |=> (result == '0));
endmodule

bind qp_trunc_cvt qp_trunc_cvt_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
  .operand(operand), .out_valid(out_valid), .result(result),
  .invalid(invalid), .inexact(inexact), .illegal_op(illegal_op)
);

// File: tb/qp_trunc_cvt_tb.sv
module qp_trunc_cvt_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [4:0]   sub_op = 5'd0;
  logic [127:0] operand = '0;
  logic         out_valid, invalid, inexact, illegal_op;
  logic [127:0] result;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qp_trunc_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
    .operand(operand), .out_valid(out_valid), .result(result),
    .invalid(invalid), .inexact(inexact), .illegal_op(illegal_op)
  );

  localparam logic [4:0] UNS = 5'b00000;
  localparam logic [4:0] SGN = 5'b01000;

  // packs {illegal, invalid, inexact, result}
  function automatic logic [130:0] model(input logic [127:0] a, input logic [4:0] op);
    logic s; int e; int ub; logic [127:0] sig; logic [127:0] m; logic lost;
    logic [127:0] smin; logic [127:0] smax;
    smin = {1'b1, 127'b0};
    smax = ~smin;
    s = a[127];
    e = int'(a[126:112]);
    sig = {15'b0, 1'b1, a[111:0]};
    if (op != UNS && op != SGN) return {1'b1, 1'b0, 1'b0, 128'b0};
    if (e == 32767) begin
      if (a[111:0] != 0) return {1'b0, 1'b1, 1'b0, (op == SGN) ? smin : 128'b0};
      if (s) return {1'b0, 1'b1, 1'b0, (op == SGN) ? smin : 128'b0};
      return {1'b0, 1'b1, 1'b0, (op == SGN) ? smax : ~128'b0};
    end
    if (e < 16383) return {1'b0, 1'b0, a[126:0] != 0, 128'b0};
    ub = e - 16383;
    if (ub >= 128) begin
      if (s) return {1'b0, 1'b1, 1'b0, (op == SGN) ? smin : 128'b0};
      return {1'b0, 1'b1, 1'b0, (op == SGN) ? smax : ~128'b0};
    end
    if (ub >= 112) begin
      m = sig << (ub - 112);
      lost = 1'b0;
    end else begin
      m = sig >> (112 - ub);
      lost = (sig & ((128'd1 << (112 - ub)) - 128'd1)) != 0;
    end
    if (op == SGN) begin
      if (s) begin
        if (m > smin) return {1'b0, 1'b1, 1'b0, smin};
        return {1'b0, 1'b0, lost, (~m) + 128'd1};
      end
      if (m >= smin) return {1'b0, 1'b1, 1'b0, smax};
      return {1'b0, 1'b0, lost, m};
    end
    if (s) return {1'b0, 1'b1, 1'b0, 128'b0};
    return {1'b0, 1'b0, lost, m};
  endfunction

  task automatic check(input string tag, input logic [130:0] got, input logic [130:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got ill=%0b inv=%0b inx=%0b res=%h expected ill=%0b inv=%0b inx=%0b res=%h",
               tag, got[130], got[129], got[128], got[127:0], exp[130], exp[129], exp[128], exp[127:0]);
    end
  endtask

  task automatic run(input string tag, input logic [127:0] a, input logic [4:0] op);
    @(negedge clk);
    operand = a; sub_op = op; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_tests++;
    if (out_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R2: out_valid=%0b expected 1", out_valid);
    end
    check(tag, {illegal_op, invalid, inexact, result}, model(a, op));
  endtask

  function automatic logic [127:0] rand_fp();
    logic [14:0] e; logic [111:0] f; int k;
    f = {$urandom, $urandom, $urandom, $urandom};
    k = $urandom % 8;
    case (k)
      0: e = 15'h7FFF;
      1: e = 15'h0;
      2: e = 15'(16382 - ($urandom % 3));
      default: e = 15'(16383 + ($urandom % 135));
    endcase
    if ($urandom % 3 == 0) f = f & ~((112'd1 << ($urandom % 112)) - 112'd1);
    if (k == 0 && ($urandom % 2 == 0)) f = '0;
    return {1'(~$urandom % 2), e, f};
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    check("R10 reset", {illegal_op, invalid, inexact, result}, 131'b0);
    n_tests++;
    if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R10: out_valid=%0b expected 0", out_valid); end
    rst_n = 1'b1;

    run("R3 one unsigned", {16'h3FFF, 112'h0}, UNS);
    run("R3 one-and-half signed", {16'h3FFF, 1'b1, 111'h0}, SGN);
    run("R3 minus one-and-half signed", {16'hBFFF, 1'b1, 111'h0}, SGN);
    run("R11 exact after inexact", {16'h4005, 112'h0}, SGN);
    run("R4 nan signed", {16'h7FFF, 1'b1, 111'h0}, SGN);
    n_tests++;
    if (result[127:64] !== 64'h8000000000000000 || result[63:0] !== 64'h0) begin
      n_fail++; $display("FAIL R4: got %h expected 8000000000000000_0000000000000000", result);
    end
    run("R4 nan unsigned", {16'hFFFF, 112'h5}, UNS);
    run("R5 two^127 signed", {1'b0, 15'h407E, 112'h0}, SGN);
    run("R5 +inf signed", {16'h7FFF, 112'h0}, SGN);
    run("R6 -two^127 exact", {1'b1, 15'h407E, 112'h0}, SGN);
    run("R6 below -two^127", {1'b1, 15'h407E, 112'h1}, SGN);
    run("R6 -inf signed", {16'hFFFF, 112'h0}, SGN);
    run("R7 minus half unsigned", {16'hBFFE, 112'h0}, UNS);
    run("R7 minus one unsigned", {16'hBFFF, 112'h0}, UNS);
    run("R8 two^128 unsigned", {1'b0, 15'h407F, 112'h0}, UNS);
    run("R8 near two^128 unsigned", {1'b0, 15'h407E, {112{1'b1}}}, UNS);
    run("R8 +inf unsigned", {16'h7FFF, 112'h0}, UNS);
    run("R9 zero", 128'h0, SGN);
    run("R9 neg zero", {1'b1, 127'h0}, UNS);
    run("R9 subnormal", {16'h0, 112'h1}, SGN);
    run("R1 illegal code", {16'h3FFF, 112'h0}, 5'b01011);
    run("R1 illegal code 2", {16'h7FFF, 112'h1}, 5'b00001);

    held = result;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      operand = rand_fp(); sub_op = SGN;
    end
    n_tests++;
    if (result !== held || out_valid !== 1'b0 || illegal_op !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 hold: got res=%h v=%0b expected res=%h v=0", result, out_valid, held);
    end

    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      op = ($urandom % 16 == 0) ? 5'($urandom) : (($urandom % 2) ? SGN : UNS);
      run("R3 random", rand_fp(), op);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule